// File: doc/BRIEF.md
# Serial SAR Converter Readout Emulator

This block stands in for the digital side of a successive-approximation converter that is read over a three-wire, read-only serial link. A host drives an active-low select line and a serial clock. A test harness supplies the 16-bit two's-complement sample on a parallel port. The block returns the result one bit at a time on a serial data line, together with an output-enable flag that models the tri-state driver. It gives a host controller a cycle-accurate peer without any analog model.

Both host lines are asynchronous to the block. Each passes through a two-flop synchronizer into the system clock domain, and edge detectors turn them into single-cycle events. A state machine with five states does the work. `S_IDLE` leaves the line undriven. `S_WAIT` counts the first serial clock falls with the line still off. `S_LEAD` drives the line low. `S_DATA` presents the sixteen result bits, MSB first. `S_TAIL` parks the line low after the LSB.

The transitions are as follows:
- idle-to-wait: a select fall, which also latches the sample.
- wait-to-lead: the fifth clock fall.
- lead-to-data: the next clock fall.
- data-to-tail: the fall that follows the LSB.
- any-to-idle: select high, which aborts the frame and clears the counters.

Top module: `sar_link_emu`

## Requirements
- R1: After reset, `sdo_oe`, `sdo` and `busy` are all 0.
- R2: While `sel_n` is high, `sdo_oe` is 0, however `sclk` toggles.
- R3: The sample word is latched when the synchronized fall of `sel_n` is detected. The harness holds `sample_in` stable for at least 4 system clocks after `sel_n` falls. Later changes of `sample_in` do not alter the frame being read.
- R4: During the first four falls of `sclk` after `sel_n` falls, `sdo_oe` stays 0 and `busy` is 1.
- R5: The fifth `sclk` fall sets `sdo_oe` to 1 with `sdo` at 0.
- R6: Falls 6 through 21 present the sample bits 15 down to 0 on `sdo`, in that order, one bit per fall.
- R7: From fall 22 onward, `sdo` is 0 and `sdo_oe` is 1 until `sel_n` rises. Any number of extra clocks is tolerated.
- R8: `busy` rises when the select fall is detected and drops on fall 22, the fall after the LSB.
- R9: A rise of `sel_n` at any point in a frame returns the block to idle, with `sdo_oe` = 0 and `busy` = 0. The next frame counts its falls from one again.
- R10: The extreme codes are sent unchanged: 0x7FFF (positive full scale), 0x8000 (negative full scale) and 0x0000 (midscale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_in | input | 16 | Two's-complement sample from the harness |
| sdo | output | 1 | Serial data, meaningful while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Driver enable; 0 models high impedance |
| busy | output | 1 | Frame in progress, before the tail |

## Verification
The bench checks every one of the 22 to 26 falls in a frame against an expected schedule.

It targets these corner cases:
- An off-by-one lead counter would either enable the driver on fall four or place bit 15 on the fifth fall.
- A design that fails to stop after the LSB would shift zeros or garbage instead of holding a clean low tail.
- A design that samples `sample_in` continuously would leak a changed harness value into the middle of a frame.
- An abort after ten falls, followed by a fresh frame, exposes a fall counter that is not cleared. That frame would enable early and emit shifted bits.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_LEAD,
        S_DATA,
        S_TAIL
    } frame_state_t;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int N       = 2,
    parameter int STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
                last  <= RST_VAL[i];
            end else begin
                chain <= {chain[STAGES-2:0], d_async[i]};
                last  <= chain[STAGES-1];
            end
        end
        assign q[i]    = chain[STAGES-1];
        assign rise[i] = chain[STAGES-1] & ~last;
        assign fall[i] = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import sar_link_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int LEAD_EDGE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_hi,
    input  logic sel_fall,
    input  logic sel_rise,
    input  logic sclk_fall,
    output logic load,
    output logic shift,
    output logic drive,
    output logic data_phase,
    output logic busy
);
    localparam int CW = $clog2(LEAD_EDGE + 1);
    localparam int BW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_WAIT = CW'(LEAD_EDGE - 1);
    localparam logic [BW-1:0] TOP_BIT   = BW'(WIDTH - 1);

    frame_state_t state, state_nx;
    logic [CW-1:0] fall_cnt;
    logic [BW-1:0] bit_idx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (sel_fall) state_nx = S_WAIT;
            S_WAIT: if (sel_hi) state_nx = S_IDLE;
                    else if (sclk_fall && fall_cnt == LAST_WAIT) state_nx = S_LEAD;
            S_LEAD: if (sel_hi) state_nx = S_IDLE;
                    else if (sclk_fall) state_nx = S_DATA;
            S_DATA: if (sel_hi) state_nx = S_IDLE;
                    else if (sclk_fall && bit_idx == '0) state_nx = S_TAIL;
            S_TAIL: if (sel_hi) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // fall counter for the lead-in and bit index for the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            bit_idx  <= TOP_BIT;
        end else if (state_nx == S_IDLE) begin
            fall_cnt <= '0;
            bit_idx  <= TOP_BIT;
        end else if (state == S_WAIT && sclk_fall) begin
            fall_cnt <= fall_cnt + 1'b1;
        end else if (state == S_DATA && sclk_fall && bit_idx != '0) begin
            bit_idx <= bit_idx - 1'b1;
        end
    end

    // outputs
    always_comb begin
        load       = (state == S_IDLE) && sel_fall;
        shift      = (state == S_DATA) && sclk_fall && !sel_hi && (bit_idx != '0);
        drive      = 1'b0;
        data_phase = 1'b0;
        busy       = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_WAIT: busy = 1'b1;
            S_LEAD: begin drive = 1'b1; busy = 1'b1; end
            S_DATA: begin drive = 1'b1; busy = 1'b1; data_phase = 1'b1; end
            S_TAIL: drive = 1'b1;
            default: ;
        endcase
    end

    // R2: a deselected link leaves the driver off on the following cycle
    a_r2_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> !drive);
    // R9: a select rise always lands in idle
    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> (state == S_IDLE));
    // R4: the lead state is only reached from the wait state on a clock fall
    a_r4_lead_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAD && $past(state) != S_LEAD) |-> $past(sclk_fall) && $past(state) == S_WAIT);
endmodule

// File: rtl/shift_out.sv
module shift_out #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             msb
);
    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= din;
        else if (shift) sreg <= {sreg[WIDTH-2:0], 1'b0};
    end
    assign msb = sreg[WIDTH-1];

    // R3: the word present at the load pulse is what the register holds
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sreg == $past(din));
    // R6: each shift advances the word by exactly one place toward the MSB
    a_r6_one_place: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> sreg == {$past(sreg[WIDTH-2:0]), 1'b0});
endmodule

// File: rtl/sar_link_emu.sv
module sar_link_emu #(
    parameter int WIDTH     = 16,
    parameter int LEAD_EDGE = 5,
    parameter int STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sclk,
    input  logic [WIDTH-1:0] sample_in,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             busy
);
    logic [1:0] s_q, s_rise, s_fall;
    logic load, shift, drive, data_phase, msb;

    // bit 1 = select (idles high), bit 0 = serial clock
    sync_edge #(.N(2), .STAGES(STAGES), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sel_n, sclk}),
        .q       (s_q),
        .rise    (s_rise),
        .fall    (s_fall)
    );

    frame_fsm #(.WIDTH(WIDTH), .LEAD_EDGE(LEAD_EDGE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_hi     (s_q[1]),
        .sel_fall   (s_fall[1]),
        .sel_rise   (s_rise[1]),
        .sclk_fall  (s_fall[0]),
        .load       (load),
        .shift      (shift),
        .drive      (drive),
        .data_phase (data_phase),
        .busy       (busy)
    );

    shift_out #(.WIDTH(WIDTH)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (sample_in),
        .msb   (msb)
    );

    assign sdo_oe = drive;
    assign sdo    = data_phase & msb;

    // R5: the driver always switches on at a low level
    a_r5_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);
    // R8: busy drops into the low tail unless the frame was aborted
    a_r8_tail_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !s_q[1]) |-> (sdo_oe && !sdo));
endmodule

// File: tb/sim_sar_link_emu.sv
module sim_sar_link_emu;
    localparam int HALF = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b1;
    logic [15:0] sample_in = '0;
    logic sdo, sdo_oe, busy;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sar_link_emu u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
        .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic sclk_fall();
        sclk = 1'b0;
        tick(HALF - 1);
    endtask

    task automatic sclk_rise();
        sclk = 1'b1;
        tick(HALF);
    endtask

    // runs a full frame of nfall clocks and checks each fall against the schedule
    task automatic run_frame(input logic [15:0] val, input int nfall, input logic [15:0] late_val);
        sample_in = val;
        sel_n = 1'b0;
        tick(6);
        sample_in = late_val;          // R3: later change must not matter
        chk("R8", "busy after select", busy, 1'b1);
        tick(HALF);
        for (int k = 1; k <= nfall; k++) begin
            sclk_fall();
            if (k <= 4) begin
                chk("R4", $sformatf("oe fall %0d", k), sdo_oe, 1'b0);
                chk("R4", $sformatf("busy fall %0d", k), busy, 1'b1);
            end else if (k == 5) begin
                chk("R5", "oe on fifth fall", sdo_oe, 1'b1);
                chk("R5", "sdo low on fifth fall", sdo, 1'b0);
            end else if (k <= 21) begin
                chk("R6", $sformatf("bit %0d", 21 - k), sdo, val[21 - k]);
                chk("R6", "oe during data", sdo_oe, 1'b1);
            end else begin
                chk("R7", $sformatf("tail sdo fall %0d", k), sdo, 1'b0);
                chk("R7", $sformatf("tail oe fall %0d", k), sdo_oe, 1'b1);
                chk("R8", $sformatf("busy low fall %0d", k), busy, 1'b0);
            end
            sclk_rise();
        end
        sel_n = 1'b1;
        tick(8);
        chk("R2", "oe after deselect", sdo_oe, 1'b0);
        chk("R9", "busy after deselect", busy, 1'b0);
    endtask

    task automatic t_reset();
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk("R1", "oe after reset", sdo_oe, 1'b0);
        chk("R1", "sdo after reset", sdo, 1'b0);
        chk("R1", "busy after reset", busy, 1'b0);
    endtask

    task automatic t_idle_clocks();
        for (int k = 0; k < 8; k++) begin
            sclk_fall();
            chk("R2", "oe with select high", sdo_oe, 1'b0);
            sclk_rise();
        end
    endtask

    task automatic t_abort();
        sample_in = 16'hFFFF;
        sel_n = 1'b0;
        tick(6 + HALF);
        for (int k = 1; k <= 10; k++) begin
            sclk_fall();
            sclk_rise();
        end
        sel_n = 1'b1;
        tick(8);
        chk("R9", "oe after abort", sdo_oe, 1'b0);
        chk("R9", "busy after abort", busy, 1'b0);
        run_frame(16'h35C9, 22, 16'h35C9);
    endtask

    initial begin
        t_reset();
        t_idle_clocks();
        run_frame(16'hA5C3, 22, 16'hA5C3);
        run_frame(16'h1234, 24, 16'hFFFF);   // R3 late change, R7 extra clocks
        run_frame(16'h7FFF, 22, 16'h0000);   // R10 positive full scale
        run_frame(16'h8000, 23, 16'h7FFF);   // R10 negative full scale
        run_frame(16'h0000, 26, 16'h8000);   // R10 midscale
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule